// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Unit

This unit holds a small file of signed path-metric accumulators and performs the add/compare/select step of a Viterbi decoder on any two of them. In one ACS operation each of the two chosen accumulators receives its own branch metric. The two candidate sums are compared as signed values, and the smaller one, taken as the better distance, survives. The survivor overwrites one of the two source accumulators. A decision bit that records which candidate won is shifted into a traceback register, which an external traceback recorder reads.

A split mode handles branch-metric arithmetic. The low part of each accumulator is treated as two independent signed 16-bit lanes. The two accumulators are added or subtracted lane by lane, with no carry between the lanes and with optional saturation in each lane. This forms the distance between a received symbol and its estimate. A load operation fills accumulators. A combinational read port shows any accumulator.

Top module: `acs_unit`

## Requirements
- R1: While `rst_n` is low on a clock edge, every accumulator, `trace_reg` and `dec_bit` become 0.
- R2: An operation is accepted on a rising edge when `op_valid` is 1. With `op_code` 2'b01 (load), `load_data` is written to accumulator `sel_a` on that edge.
- R3: With `op_code` 2'b10 (ACS), candidate 0 is acc[`sel_a`] plus sign-extended `bm0` and candidate 1 is acc[`sel_b`] plus sign-extended `bm1`. The signed smaller candidate is written to acc[`sel_a`] when `wr_second` is 0, or to acc[`sel_b`] when it is 1. All other accumulators keep their values.
- R4: If candidate 1 is strictly smaller, the ACS decision is 1. Otherwise the decision is 0, so a tie selects candidate 0. `dec_bit` holds the decision of the most recent ACS.
- R5: Each ACS shifts `trace_reg` left by one and places the new decision in bit 0, so after 16 operations the first decision is in bit 15. Load and split operations leave `trace_reg` unchanged.
- R6: With `op_code` 2'b11 (split), bits [15:0] and [31:16] of the result are the lane-wise sum, or the lane-wise difference acc[`sel_a`] minus acc[`sel_b`] when `split_sub` is 1. No carry or borrow passes between the lanes. Bits [39:32] of the result copy bit 31, and bits [39:32] of the sources are ignored. The result goes to the accumulator chosen by `wr_second`, as in R3.
- R7: In split mode with `sat_en` set to 1, a lane that overflows becomes 16'h7FFF or 16'h8000 depending on the sign of the true result. With `sat_en` set to 0, the lane wraps.
- R8: In ACS mode with `sat_en` set to 1, a candidate that overflows 40 bits becomes the largest or smallest 40-bit value. With `sat_en` set to 0, it wraps. The compare uses the candidates after this step.
- R9: An edge where `op_valid` is 0, or where `op_code` is 2'b00, changes no accumulator, no `trace_reg` bit and no `dec_bit`.
- R10: `sel_a` and `sel_b` may name the same accumulator. Both candidates are then formed from that accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation accepted on this edge |
| op_code | input | 2 | 00 none, 01 load, 10 ACS, 11 split |
| sel_a | input | 3 | First source accumulator, and the load target |
| sel_b | input | 3 | Second source accumulator |
| wr_second | input | 1 | Result target: 0 selects sel_a, 1 selects sel_b |
| sat_en | input | 1 | Saturation enable for ACS and split |
| split_sub | input | 1 | Split mode: 1 subtracts, 0 adds |
| bm0 | input | 16 | Branch metric for the first candidate |
| bm1 | input | 16 | Branch metric for the second candidate |
| load_data | input | 40 | Value written by load |
| rd_sel | input | 3 | Accumulator shown on rd_data |
| rd_data | output | 40 | Combinational view of acc[rd_sel] |
| dec_bit | output | 1 | Decision of the latest ACS |
| trace_reg | output | 16 | Traceback shift register of decisions |

## Verification
Each operation takes effect on the rising edge at which it is presented. The written accumulator is visible on `rd_data` as soon as that edge has passed, and `dec_bit` and `trace_reg` change on the same edge. The bench sets inputs on a falling edge and lets one rising edge pass. It then drops `op_valid` at the next falling edge and reads the results before the following rising edge, so every sample falls exactly one edge after its stimulus. Accumulators that the operation must not touch are read back through `rd_sel` in the same window.

// File: rtl/acs_pkg.sv
// Shared operation codes for the add-compare-select unit.
// Assumes a two-bit operation field at the block edge.
package acs_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_ACS   = 2'b10,
        OP_SPLIT = 2'b11
    } acs_op_e;
endpackage

// File: rtl/acs_sat_add.sv
// Signed adder/subtractor of width W with optional clamp on overflow.
// Assumes two's complement operands of equal width; purely combinational.
module acs_sat_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         sat_en,
    output logic [W-1:0] y
);
    logic [W:0] ax;
    logic [W:0] bx;
    logic [W:0] sum;

    // Add or subtract with one guard bit, then clamp when requested.
    always_comb begin
        ax  = {a[W-1], a};
        bx  = {b[W-1], b};
        sum = sub ? (ax - bx) : (ax + bx);
        if (sat_en && (sum[W] != sum[W-1]))
            y = sum[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else
            y = sum[W-1:0];
    end
endmodule

// File: rtl/acs_accfile.sv
// Accumulator file: N_ACC words of W bits, one write port, three read ports.
// Assumes at most one write per cycle; reads are combinational.
module acs_accfile #(
    parameter int N_ACC = 8,
    parameter int W     = 40,
    localparam int IW   = $clog2(N_ACC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] wsel,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ra,
    input  logic [IW-1:0] rb,
    input  logic [IW-1:0] rr,
    output logic [W-1:0]  da,
    output logic [W-1:0]  db,
    output logic [W-1:0]  dr
);
    logic [N_ACC-1:0][W-1:0] mem;

    // Storage update: clear on reset, otherwise write the selected word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (we) begin
            for (int i = 0; i < N_ACC; i++)
                if (wsel == IW'(i)) mem[i] <= wdata;
        end
    end

    // Read ports.
    assign da = mem[ra];
    assign db = mem[rb];
    assign dr = mem[rr];
endmodule

// File: rtl/acs_select.sv
// ACS datapath: adds a branch metric to each path metric, keeps the smaller.
// Assumes signed metrics; a tie keeps candidate 0 and reports decision 0.
module acs_select #(
    parameter int W    = 40,
    parameter int BM_W = 16
) (
    input  logic [W-1:0]    pa,
    input  logic [W-1:0]    pb,
    input  logic [BM_W-1:0] bm0,
    input  logic [BM_W-1:0] bm1,
    input  logic            sat_en,
    output logic [W-1:0]    survivor,
    output logic            dec
);
    logic [W-1:0] bx0;
    logic [W-1:0] bx1;
    logic [W-1:0] cand0;
    logic [W-1:0] cand1;

    assign bx0 = {{(W-BM_W){bm0[BM_W-1]}}, bm0};
    assign bx1 = {{(W-BM_W){bm1[BM_W-1]}}, bm1};

    acs_sat_add #(.W(W)) u_add0 (.a(pa), .b(bx0), .sub(1'b0), .sat_en(sat_en), .y(cand0));
    acs_sat_add #(.W(W)) u_add1 (.a(pb), .b(bx1), .sub(1'b0), .sat_en(sat_en), .y(cand1));

    // Compare and select the surviving metric.
    always_comb begin
        dec      = $signed(cand1) < $signed(cand0);
        survivor = dec ? cand1 : cand0;
    end
endmodule

// File: rtl/acs_unit.sv
// Top of the add-compare-select unit: accumulator file, ACS path, split
// lane ALU and traceback shift register. One operation per clock; results
// and decisions land on the edge the operation is accepted.
module acs_unit
    import acs_pkg::*;
#(
    parameter int N_ACC  = 8,
    parameter int ACC_W  = 40,
    parameter int BM_W   = 16,
    parameter int LANE_W = 16,
    parameter int N_LANE = 2,
    parameter int TB_W   = 16,
    localparam int IDX_W = $clog2(N_ACC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_code,
    input  logic [IDX_W-1:0] sel_a,
    input  logic [IDX_W-1:0] sel_b,
    input  logic             wr_second,
    input  logic             sat_en,
    input  logic             split_sub,
    input  logic [BM_W-1:0]  bm0,
    input  logic [BM_W-1:0]  bm1,
    input  logic [ACC_W-1:0] load_data,
    input  logic [IDX_W-1:0] rd_sel,
    output logic [ACC_W-1:0] rd_data,
    output logic             dec_bit,
    output logic [TB_W-1:0]  trace_reg
);
    localparam int SPLIT_W = N_LANE * LANE_W;

    acs_op_e          op;
    logic             do_load;
    logic             do_acs;
    logic             do_split;
    logic [ACC_W-1:0] da;
    logic [ACC_W-1:0] db;
    logic [ACC_W-1:0] survivor;
    logic             dec;
    logic [SPLIT_W-1:0] split_y;
    logic [ACC_W-1:0] split_word;
    logic             we;
    logic [IDX_W-1:0] wsel;
    logic [ACC_W-1:0] wdata;

    // Operation decode.
    always_comb begin
        op       = acs_op_e'(op_code);
        do_load  = op_valid && (op == OP_LOAD);
        do_acs   = op_valid && (op == OP_ACS);
        do_split = op_valid && (op == OP_SPLIT);
    end

    acs_accfile #(.N_ACC(N_ACC), .W(ACC_W)) u_file (
        .clk(clk), .rst_n(rst_n), .we(we), .wsel(wsel), .wdata(wdata),
        .ra(sel_a), .rb(sel_b), .rr(rd_sel),
        .da(da), .db(db), .dr(rd_data)
    );

    acs_select #(.W(ACC_W), .BM_W(BM_W)) u_sel (
        .pa(da), .pb(db), .bm0(bm0), .bm1(bm1), .sat_en(sat_en),
        .survivor(survivor), .dec(dec)
    );

    // Split lanes: independent adders, no carry path between them.
    for (genvar l = 0; l < N_LANE; l++) begin : g_lane
        acs_sat_add #(.W(LANE_W)) u_lane (
            .a(da[l*LANE_W +: LANE_W]),
            .b(db[l*LANE_W +: LANE_W]),
            .sub(split_sub),
            .sat_en(sat_en),
            .y(split_y[l*LANE_W +: LANE_W])
        );
    end

    assign split_word = {{(ACC_W-SPLIT_W){split_y[SPLIT_W-1]}}, split_y};

    // Write-back target and data selection.
    always_comb begin
        we    = do_load || do_acs || do_split;
        wsel  = (do_load || !wr_second) ? sel_a : sel_b;
        if (do_load)      wdata = load_data;
        else if (do_acs)  wdata = survivor;
        else              wdata = split_word;
    end

    // Decision capture and traceback shift on each ACS.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trace_reg <= '0;
            dec_bit   <= 1'b0;
        end else if (do_acs) begin
            trace_reg <= {trace_reg[TB_W-2:0], dec};
            dec_bit   <= dec;
        end
    end
endmodule

// File: rtl/acs_unit_chk.sv
// Checker for acs_unit: traceback, hold and load behaviour at the ports.
// Assumes the default 16-bit traceback register and 40-bit accumulators.
module acs_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [1:0]  op_code,
    input logic [2:0]  sel_a,
    input logic [2:0]  rd_sel,
    input logic [39:0] load_data,
    input logic [39:0] rd_data,
    input logic        dec_bit,
    input logic [15:0] trace_reg
);
    logic past_ok;

    // Marks cycles whose predecessor was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (trace_reg == 16'h0) && !dec_bit);

    p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && op_valid && op_code == 2'b10) |=>
        (trace_reg[15:1] == $past(trace_reg[14:0])) && (trace_reg[0] == dec_bit));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !(op_valid && op_code == 2'b10)) |=>
        ($stable(trace_reg) && $stable(dec_bit)));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && op_valid && op_code == 2'b01) |=>
        ((rd_sel != $past(sel_a)) || (rd_data == $past(load_data))));
endmodule

bind acs_unit acs_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .sel_a(sel_a), .rd_sel(rd_sel), .load_data(load_data), .rd_data(rd_data),
    .dec_bit(dec_bit), .trace_reg(trace_reg)
);

// File: tb/acs_unit_test.sv
module acs_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [1:0]  op_code;
    logic [2:0]  sel_a, sel_b, rd_sel;
    logic        wr_second, sat_en, split_sub;
    logic [15:0] bm0, bm1;
    logic [39:0] load_data;
    logic [39:0] rd_data;
    logic        dec_bit;
    logic [15:0] trace_reg;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [39:0] m_acc [8];
    logic [15:0] m_tr;

    always #5 clk = ~clk;

    acs_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .sel_a(sel_a), .sel_b(sel_b), .wr_second(wr_second), .sat_en(sat_en),
        .split_sub(split_sub), .bm0(bm0), .bm1(bm1), .load_data(load_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .dec_bit(dec_bit), .trace_reg(trace_reg)
    );

    function automatic logic [39:0] f_add40(logic [39:0] a, logic [15:0] b, bit sat);
        longint s;
        longint mx;
        mx = (64'sd1 <<< 39) - 1;
        s = longint'($signed(a)) + longint'($signed(b));
        if (sat && s > mx) s = mx;
        if (sat && s < -mx - 1) s = -mx - 1;
        return s[39:0];
    endfunction

    function automatic logic [15:0] f_lane(logic [15:0] a, logic [15:0] b, bit sub, bit sat);
        int s;
        s = sub ? (int'($signed(a)) - int'($signed(b))) : (int'($signed(a)) + int'($signed(b)));
        if (sat && s > 32767) s = 32767;
        if (sat && s < -32768) s = -32768;
        return s[15:0];
    endfunction

    function automatic logic [39:0] f_split(logic [39:0] a, logic [39:0] b, bit sub, bit sat);
        logic [15:0] lo, hi;
        lo = f_lane(a[15:0], b[15:0], sub, sat);
        hi = f_lane(a[31:16], b[31:16], sub, sat);
        return {{8{hi[15]}}, hi, lo};
    endfunction

    task automatic check(string req, logic [39:0] act, logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [2:0] idx, output logic [39:0] v);
        rd_sel = idx;
        #1;
        v = rd_data;
    endtask

    task automatic idle_inputs();
        op_valid = 0; op_code = 2'b00; sel_a = 0; sel_b = 0; wr_second = 0;
        sat_en = 0; split_sub = 0; bm0 = 0; bm1 = 0; load_data = 0; rd_sel = 0;
    endtask

    // Present one operation at a falling edge; it executes on the next rising edge.
    task automatic issue(logic [1:0] code, logic [2:0] a, logic [2:0] b, bit ws,
                         bit sat, bit sub, logic [15:0] b0, logic [15:0] b1, logic [39:0] ld);
        @(negedge clk);
        op_valid = 1; op_code = code; sel_a = a; sel_b = b; wr_second = ws;
        sat_en = sat; split_sub = sub; bm0 = b0; bm1 = b1; load_data = ld;
        @(negedge clk);
        op_valid = 0;
    endtask

    task automatic do_load(logic [2:0] i, logic [39:0] v);
        issue(2'b01, i, 3'd0, 0, 0, 0, 16'h0, 16'h0, v);
        m_acc[i] = v;
    endtask

    // Run an ACS; check the written word, the decision and the trace register.
    task automatic do_acs(string req, logic [2:0] a, logic [2:0] b, bit ws, bit sat,
                          logic [15:0] b0, logic [15:0] b1, bit exp_dec);
        logic [39:0] c0, c1, sv, v;
        bit d;
        logic [2:0] dst;
        c0 = f_add40(m_acc[a], b0, sat);
        c1 = f_add40(m_acc[b], b1, sat);
        d  = $signed(c1) < $signed(c0);
        sv = d ? c1 : c0;
        dst = ws ? b : a;
        issue(2'b10, a, b, ws, sat, 0, b0, b1, 40'h0);
        m_acc[dst] = sv;
        m_tr = {m_tr[14:0], d};
        rd(dst, v);
        check({req, " survivor"}, v, sv);
        check({req, " decision"}, {39'h0, dec_bit}, {39'h0, exp_dec});
        check("R5 trace", {24'h0, trace_reg}, {24'h0, m_tr});
    endtask

    task automatic check_all(string req);
        logic [39:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            check(req, v, m_acc[i]);
        end
    endtask

    task automatic t_reset();
        check_all("R1 acc cleared");
        check("R1 trace cleared", {24'h0, trace_reg}, 40'h0);
        check("R1 dec cleared", {39'h0, dec_bit}, 40'h0);
    endtask

    task automatic t_load();
        for (int i = 0; i < 8; i++) do_load(3'(i), 40'h11_0000_0000 * (i + 1) + 40'(i * 3));
        check_all("R2 load");
    endtask

    task automatic t_acs_basic();
        do_load(0, 40'd100);
        do_load(1, 40'd50);
        do_acs("R3 second wins", 0, 1, 0, 0, 16'd10, 16'd20, 1);
        check_all("R3 others unchanged");
        do_load(4, -40'sd20);
        do_load(5, 40'd0);
        do_acs("R3 signed first wins", 4, 5, 0, 0, 16'hFFFD, 16'd1, 0);
    endtask

    task automatic t_tie();
        do_load(2, 40'd5);
        do_load(3, 40'd7);
        do_acs("R4 tie picks first", 2, 3, 1, 0, 16'd4, 16'd2, 0);
        check_all("R4 source untouched");
    endtask

    task automatic t_sat_acs();
        do_load(6, 40'h7F_FFFF_FFF0);
        do_acs("R8 R10 clamp high", 6, 6, 0, 1, 16'h0100, 16'h0100, 0);
        check("R8 clamp value", m_acc[6], 40'h7F_FFFF_FFFF);
        do_load(6, 40'h7F_FFFF_FFF0);
        do_acs("R8 R10 wrap", 6, 6, 0, 0, 16'h0100, 16'h0100, 0);
        check("R8 wrap value", m_acc[6], 40'h80_0000_00F0);
    endtask

    task automatic t_split();
        logic [39:0] v, e;
        logic [15:0] tr0;
        do_load(0, 40'h5A_0001_FFFF);
        do_load(1, 40'hA5_0002_0001);
        tr0 = trace_reg;
        issue(2'b11, 0, 1, 1, 0, 0, 16'h0, 16'h0, 40'h0);
        e = f_split(m_acc[0], m_acc[1], 0, 0);
        m_acc[1] = e;
        rd(1, v);
        check("R6 split add no carry", v, 40'h00_0003_0000);
        check("R6 split add model", v, e);
        check("R5 split keeps trace", {24'h0, trace_reg}, {24'h0, tr0});
        issue(2'b11, 0, 0, 0, 0, 1, 16'h0, 16'h0, 40'h0);
        m_acc[0] = 40'h0;
        rd(0, v);
        check("R6 split sub self", v, 40'h0);
        do_load(2, 40'h00_0001_FFFF);
        do_load(3, 40'h00_0002_0001);
        issue(2'b11, 2, 3, 0, 0, 1, 16'h0, 16'h0, 40'h0);
        rd(2, v);
        check("R6 split sub sign ext", v, 40'hFF_FFFF_FFFE);
        do_load(4, 40'h00_8000_7FFF);
        do_load(5, 40'h00_0001_0001);
        issue(2'b11, 4, 5, 0, 1, 0, 16'h0, 16'h0, 40'h0);
        rd(4, v);
        check("R7 lane clamp add", v, 40'hFF_8001_7FFF);
        do_load(4, 40'h00_8000_7FFF);
        issue(2'b11, 4, 5, 0, 1, 1, 16'h0, 16'h0, 40'h0);
        rd(4, v);
        check("R7 lane clamp sub", v, 40'hFF_8000_7FFE);
        do_load(4, 40'h00_8000_7FFF);
        issue(2'b11, 4, 5, 0, 0, 0, 16'h0, 16'h0, 40'h0);
        rd(4, v);
        check("R7 lane wrap add", v, 40'hFF_8001_8000);
        do_load(4, 40'h00_8000_7FFF);
        issue(2'b11, 4, 5, 0, 0, 1, 16'h0, 16'h0, 40'h0);
        rd(4, v);
        check("R7 lane wrap sub", v, 40'h00_7FFF_7FFE);
        m_acc[4] = v;
        for (int i = 0; i < 4; i++) m_acc[i] = m_acc[i];
        m_acc[2] = 40'hFF_FFFF_FFFE;
    endtask

    task automatic t_hold();
        logic [15:0] tr0;
        bit d0;
        tr0 = trace_reg;
        d0 = dec_bit;
        issue(2'b00, 1, 2, 1, 1, 1, 16'h7, 16'h9, 40'h12_3456_789A);
        @(negedge clk);
        op_valid = 0; op_code = 2'b10; sel_a = 0; sel_b = 1; bm0 = 16'h8000; bm1 = 16'h7FFF;
        @(negedge clk);
        op_code = 2'b01; load_data = 40'hDE_AD00_BEEF;
        @(negedge clk);
        op_code = 2'b00;
        check_all("R9 no write");
        check("R9 trace held", {24'h0, trace_reg}, {24'h0, tr0});
        check("R9 dec held", {39'h0, dec_bit}, {39'h0, d0});
    endtask

    task automatic t_trace();
        logic [15:0] pat;
        pat = 16'b1011_0010_1110_0001;
        do_load(0, 40'h0);
        do_load(1, 40'h0);
        for (int k = 15; k >= 0; k--)
            do_acs("R4 pattern decision", 0, 1, 0, 0, pat[k] ? 16'd1 : 16'd0, 16'd0, pat[k]);
        check("R5 MSB first", {24'h0, trace_reg}, {24'h0, pat});
    endtask

    initial begin
        idle_inputs();
        m_tr = 16'h0;
        for (int i = 0; i < 8; i++) m_acc[i] = 40'h0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_load();
        t_acs_basic();
        t_tie();
        t_sat_acs();
        t_split();
        t_hold();
        t_trace();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule